// File: doc/BRIEF.md
# Configurable Boolean Gate Network

This block evaluates a small Boolean network that is set up entirely by configuration inputs. It has eight input bits and eight gates, and each gate has four pins. Every pin has an enable bit, an invert bit and a 4-bit source pointer into a shared space of sixteen sources: the eight input bits followed by the eight gate results. Each gate applies one of six functions to its pins: AND, OR, XOR, majority, set/reset with dominant pins, or A/B select. A final selector, with optional inversion, picks one source as the network result.

A gate may read only inputs and lower-numbered gates. All gates are therefore evaluated in one ascending combinational pass, and the whole state is registered once per clock. The block reports the live input bits, the gate results and the wire state of every pin, so that a monitor can show how the result was formed. It also reports per gate whether the function code, a pointer or the pin-enable pattern is illegal.

Top module: `bgn_net`

## Requirements
- R1: All outputs are registered. A change on any input or configuration port shows at the outputs after the next rising clock edge and not before. While `rst_ni` is low, every output is 0 and every set/reset gate state is 0. `inp_live_o` mirrors `inp_i`.
- R2: A source pointer value of 0 to 7 selects `inp_i[v]`. A value of 8 to 15 selects the result of gate v-8. Pin p of gate g uses enable bit `g*4+p`, invert bit `g*4+p` and pointer bits `[(g*4+p)*4 +: 4]`. Function code bits for gate g are `[g*3 +: 3]`.
- R3: The wire state of a pin is (source XOR invert) when the pin is enabled and 0 when it is disabled. It is reported on `pin_live_o` bit `g*4+p`.
- R4: Code 1 (AND) is true when every enabled pin is true. Code 2 (OR) is true when any pin is true. Code 3 (XOR) is true when an odd number of pins are true.
- R5: Code 4 (majority) is true when more than half of the enabled pins are true. That is 2 of 2, 2 of 3, or 3 of 4.
- R6: Code 6 (select) outputs pin 0 when pin 2 is false and pin 1 when pin 2 is true.
- R7: Code 5 (set/reset) uses pin 1 as the dominant reset, pin 0 as the dominant set, pin 3 as a plain reset and pin 2 as a plain set, in that priority order. With no active pin, the gate holds its state.
- R8: Code 0 marks an unused gate, which outputs 0 with no error. Code 7 raises `err_func_o[g]`. A gate with any error outputs 0, and its set/reset state is cleared.
- R9: `err_mask_o[g]` is raised in these cases: codes 1, 2, 3 or 5 with no pin enabled; code 4 with fewer than two pins enabled; code 6 without pin 2 enabled or without pin 0 or pin 1 enabled.
- R10: An enabled pin whose pointer names gate g or any higher gate raises `err_ptr_o[g]`, and that pin reads 0. A disabled pin's pointer is never checked.
- R11: `result_o` is the source selected by `cfg_out_ptr_i` (same source map as R2), XOR `cfg_out_inv_i`.
- R12: A gate that reads a lower gate sees that gate's result from the same evaluation, so a chain of gates settles in a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inp_i | input | 8 | Logic input bits |
| cfg_func_i | input | 24 | Function code per gate, 3 bits each |
| cfg_en_i | input | 32 | Pin enable bits |
| cfg_inv_i | input | 32 | Pin invert bits |
| cfg_ptr_i | input | 128 | Pin source pointers, 4 bits each |
| cfg_out_ptr_i | input | 4 | Source pointer of the result |
| cfg_out_inv_i | input | 1 | Invert the result |
| inp_live_o | output | 8 | Registered input bits |
| gate_live_o | output | 8 | Registered gate results |
| pin_live_o | output | 32 | Registered pin wire states |
| err_func_o | output | 8 | Per-gate illegal function code |
| err_ptr_o | output | 8 | Per-gate illegal pointer |
| err_mask_o | output | 8 | Per-gate illegal pin-enable pattern |
| result_o | output | 1 | Selected, optionally inverted result |

## Verification
Every result is due exactly one rising edge after its stimulus, and a set/reset gate's new state appears at that same edge. The bench drives inputs and configuration on the falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. It also samples once just after driving, before any edge, to confirm that nothing appears early. For the set/reset sequence, the bench's model state advances once per step, matching the single state update per edge.

// File: rtl/bgn_pkg.sv
package bgn_pkg;
  localparam int FUNC_W  = 3;
  localparam int MAX_PIN = 8;

  typedef enum logic [FUNC_W-1:0] {
    FN_NONE = 3'd0,
    FN_AND  = 3'd1,
    FN_OR   = 3'd2,
    FN_XOR  = 3'd3,
    FN_MAJ  = 3'd4,
    FN_SR   = 3'd5,
    FN_SEL  = 3'd6
  } fn_e;

  function automatic int unsigned ones(input logic [MAX_PIN-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_PIN; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/bgn_gate.sv
module bgn_gate
  import bgn_pkg::*;
#(
  parameter int N_INP = 8,
  parameter int N_PIN = 4,
  parameter int N_SRC = 16,
  parameter int PTR_W = 4,
  parameter int IDX   = 0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_i,
  input  logic [FUNC_W-1:0]      func_i,
  input  logic [N_PIN-1:0]       en_i,
  input  logic [N_PIN-1:0]       inv_i,
  input  logic [N_PIN*PTR_W-1:0] ptr_i,
  output logic [N_PIN-1:0]       pin_o,
  output logic                   y_o,
  output logic                   err_func_o,
  output logic                   err_ptr_o,
  output logic                   err_mask_o
);
  // first source index this gate may not read
  localparam int LIM = N_INP + IDX;

  logic [N_PIN-1:0] bad;
  logic             err, raw, sr_q, sr_d;
  int unsigned      n_en, n_hi;

  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    logic [PTR_W-1:0] ptr;
    assign ptr      = ptr_i[p*PTR_W +: PTR_W];
    assign bad[p]   = en_i[p] && (int'(ptr) >= LIM);
    assign pin_o[p] = en_i[p] && !bad[p] && (src_i[ptr] ^ inv_i[p]);
  end

  always_comb begin
    n_en = ones(MAX_PIN'(en_i));
    n_hi = ones(MAX_PIN'(pin_o));

    // priority: dominant reset, dominant set, plain reset, plain set
    sr_d = sr_q;
    if (pin_o[1])      sr_d = 1'b0;
    else if (pin_o[0]) sr_d = 1'b1;
    else if (pin_o[3]) sr_d = 1'b0;
    else if (pin_o[2]) sr_d = 1'b1;

    err_func_o = func_i > FUNC_W'(FN_SEL);
    err_ptr_o  = |bad;

    err_mask_o = 1'b0;
    case (func_i)
      FN_AND, FN_OR, FN_XOR, FN_SR: err_mask_o = (en_i == '0);
      FN_MAJ: err_mask_o = (n_en < 2);
      FN_SEL: err_mask_o = !en_i[2] || !(en_i[0] || en_i[1]);
      default: err_mask_o = 1'b0;
    endcase

    raw = 1'b0;
    case (func_i)
      FN_AND: raw = &(pin_o | ~en_i);
      FN_OR:  raw = |pin_o;
      FN_XOR: raw = ^pin_o;
      FN_MAJ: raw = (2 * n_hi) > n_en;
      FN_SR:  raw = sr_d;
      FN_SEL: raw = pin_o[2] ? pin_o[1] : pin_o[0];
      default: raw = 1'b0;
    endcase

    err = err_func_o || err_ptr_o || err_mask_o;
    y_o = raw && !err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= 1'b0;
    else         sr_q <= (func_i == FN_SR && !err) ? sr_d : 1'b0;
  end

  // R7
  sr_dom_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i == FN_SR && !err && pin_o[1]) |=> !sr_q);

  // R7
  sr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i == FN_SR && !err && pin_o == '0) |=> $stable(sr_q));

  // R6
  sel_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i == FN_SEL && !err && pin_o[2]) |-> (y_o == pin_o[1]));
endmodule

// File: rtl/bgn_out_sel.sv
module bgn_out_sel #(
  parameter int N_SRC = 16,
  parameter int PTR_W = 4
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             inv_i,
  output logic             bit_o
);
  assign bit_o = src_i[ptr_i] ^ inv_i;
endmodule

// File: rtl/bgn_net.sv
module bgn_net
  import bgn_pkg::*;
#(
  parameter int  N_INP  = 8,
  parameter int  N_GATE = 8,
  parameter int  N_PIN  = 4,
  localparam int N_SRC  = N_INP + N_GATE,
  localparam int PTR_W  = $clog2(N_SRC)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_INP-1:0]              inp_i,
  input  logic [N_GATE*FUNC_W-1:0]      cfg_func_i,
  input  logic [N_GATE*N_PIN-1:0]       cfg_en_i,
  input  logic [N_GATE*N_PIN-1:0]       cfg_inv_i,
  input  logic [N_GATE*N_PIN*PTR_W-1:0] cfg_ptr_i,
  input  logic [PTR_W-1:0]              cfg_out_ptr_i,
  input  logic                          cfg_out_inv_i,
  output logic [N_INP-1:0]              inp_live_o,
  output logic [N_GATE-1:0]             gate_live_o,
  output logic [N_GATE*N_PIN-1:0]       pin_live_o,
  output logic [N_GATE-1:0]             err_func_o,
  output logic [N_GATE-1:0]             err_ptr_o,
  output logic [N_GATE-1:0]             err_mask_o,
  output logic                          result_o
);
  logic [N_GATE-1:0]       gate_y, e_func, e_ptr, e_mask;
  logic [N_GATE*N_PIN-1:0] pin_w;
  logic                    res_d;

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    // only inputs and lower gates are wired in; the rest read 0
    logic [N_SRC-1:0] avail;
    for (genvar j = 0; j < N_SRC; j++) begin : g_src
      if (j < N_INP) begin : g_in
        assign avail[j] = inp_i[j];
      end else if (j - N_INP < g) begin : g_lo
        assign avail[j] = gate_y[j-N_INP];
      end else begin : g_hi
        assign avail[j] = 1'b0;
      end
    end

    bgn_gate #(
      .N_INP(N_INP), .N_PIN(N_PIN), .N_SRC(N_SRC), .PTR_W(PTR_W), .IDX(g)
    ) u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (avail),
      .func_i     (cfg_func_i[g*FUNC_W +: FUNC_W]),
      .en_i       (cfg_en_i[g*N_PIN +: N_PIN]),
      .inv_i      (cfg_inv_i[g*N_PIN +: N_PIN]),
      .ptr_i      (cfg_ptr_i[g*N_PIN*PTR_W +: N_PIN*PTR_W]),
      .pin_o      (pin_w[g*N_PIN +: N_PIN]),
      .y_o        (gate_y[g]),
      .err_func_o (e_func[g]),
      .err_ptr_o  (e_ptr[g]),
      .err_mask_o (e_mask[g])
    );

    // R8
    err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_func_o[g] || err_ptr_o[g] || err_mask_o[g]) |-> !gate_live_o[g]);

    // R8
    func_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cfg_func_i[g*FUNC_W +: FUNC_W]) == 3'd7) |-> err_func_o[g]);
  end

  bgn_out_sel #(.N_SRC(N_SRC), .PTR_W(PTR_W)) u_out (
    .src_i (({gate_y, inp_i})),
    .ptr_i (cfg_out_ptr_i),
    .inv_i (cfg_out_inv_i),
    .bit_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inp_live_o  <= '0;
      gate_live_o <= '0;
      pin_live_o  <= '0;
      err_func_o  <= '0;
      err_ptr_o   <= '0;
      err_mask_o  <= '0;
      result_o    <= 1'b0;
    end else begin
      inp_live_o  <= inp_i;
      gate_live_o <= gate_y;
      pin_live_o  <= pin_w;
      err_func_o  <= e_func;
      err_ptr_o   <= e_ptr;
      err_mask_o  <= e_mask;
      result_o    <= res_d;
    end
  end

  for (genvar i = 0; i < N_GATE*N_PIN; i++) begin : g_pchk
    // R3
    dis_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(cfg_en_i[i]) |-> !pin_live_o[i]);
  end
endmodule

// File: tb/bgn_net_bench.sv
`timescale 1ns/1ps
module bgn_net_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   inp = '0;
  logic [23:0]  cfg_func = '0;
  logic [31:0]  cfg_en = '0, cfg_inv = '0;
  logic [127:0] cfg_ptr = '0;
  logic [3:0]   cfg_out_ptr = '0;
  logic         cfg_out_inv = 1'b0;
  logic [7:0]   inp_live, gate_live, err_func, err_ptr, err_mask;
  logic [31:0]  pin_live;
  logic         result;
  int           n_chk = 0, n_err = 0;
  bit           done = 0;

  always #4 clk = ~clk;

  bgn_net u_bgn_net (
    .clk_i(clk), .rst_ni(rst_n), .inp_i(inp), .cfg_func_i(cfg_func),
    .cfg_en_i(cfg_en), .cfg_inv_i(cfg_inv), .cfg_ptr_i(cfg_ptr),
    .cfg_out_ptr_i(cfg_out_ptr), .cfg_out_inv_i(cfg_out_inv),
    .inp_live_o(inp_live), .gate_live_o(gate_live), .pin_live_o(pin_live),
    .err_func_o(err_func), .err_ptr_o(err_ptr), .err_mask_o(err_mask),
    .result_o(result)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_gate(input int g, input logic [2:0] f, input logic [3:0] en,
                          input logic [3:0] inv, input logic [15:0] ptrs);
    cfg_func[g*3 +: 3]  = f;
    cfg_en[g*4 +: 4]    = en;
    cfg_inv[g*4 +: 4]   = inv;
    cfg_ptr[g*16 +: 16] = ptrs;
  endtask

  task automatic clear_cfg();
    cfg_func = '0; cfg_en = '0; cfg_inv = '0; cfg_ptr = '0;
    cfg_out_ptr = '0; cfg_out_inv = 1'b0;
  endtask

  function automatic int cnt4(input logic [3:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
  endfunction

  // returns {err, y} for a gate whose pins carry pins (already masked)
  function automatic logic [1:0] model(input int f, input logic [3:0] en, input logic [3:0] pins);
    logic e, y;
    case (f)
      1: begin e = (en == 0); y = &(pins | ~en); end
      2: begin e = (en == 0); y = |pins; end
      3: begin e = (en == 0); y = ^pins; end
      4: begin e = cnt4(en) < 2; y = 2 * cnt4(pins) > cnt4(en); end
      6: begin e = !en[2] || !(en[0] || en[1]); y = pins[2] ? pins[1] : pins[0]; end
      default: begin e = 1'b0; y = 1'b0; end
    endcase
    return {e, y && !e};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] invs [3];
    invs[0] = 4'h0; invs[1] = 4'h5; invs[2] = 4'hF;

    // R1 reset state
    inp = 8'hFF; cfg_func = '1; cfg_en = '1; cfg_out_inv = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {inp_live, gate_live, pin_live, err_func, err_ptr, err_mask, 7'd0, result}, '0);
    clear_cfg(); inp = '0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 latency: nothing before the edge, value after it
    inp = 8'hA5;
    #1 chk("R1 no early change", {56'd0, inp_live}, 64'h00);
    @(negedge clk);
    chk("R1 input mirror", {56'd0, inp_live}, 64'hA5);

    // R4 R5 R3 R9 sweep on gate 0, pins from inputs 0..3
    for (int f = 1; f <= 4; f++)
      for (int k = 0; k < 3; k++)
        for (int en = 0; en < 16; en++)
          for (int iv = 0; iv < 16; iv++) begin
            logic [3:0] pins;
            logic [1:0] m;
            set_gate(0, 3'(f), 4'(en), invs[k], 16'h3210);
            cfg_out_ptr = 4'd8; cfg_out_inv = 1'b0;
            inp = {4'h0, 4'(iv)};
            pins = 4'(en) & (4'(iv) ^ invs[k]);
            m = model(f, 4'(en), pins);
            @(negedge clk);
            chk(f == 4 ? "R5 majority" : "R4 and/or/xor", {63'd0, gate_live[0]}, {63'd0, m[0]});
            chk("R3 pin wire", {60'd0, pin_live[3:0]}, {60'd0, pins});
            chk("R9 mask error", {63'd0, err_mask[0]}, {63'd0, m[1]});
            chk("R11 result follows gate", {63'd0, result}, {63'd0, m[0]});
          end

    // R6 select sweep
    for (int en = 0; en < 16; en++)
      for (int iv = 0; iv < 16; iv++) begin
        logic [3:0] pins;
        logic [1:0] m;
        set_gate(0, 3'd6, 4'(en), 4'h0, 16'h3210);
        inp = {4'h0, 4'(iv)};
        pins = 4'(en) & 4'(iv);
        m = model(6, 4'(en), pins);
        @(negedge clk);
        chk("R6 select", {62'd0, err_mask[0], gate_live[0]}, {62'd0, m});
      end

    // R7 set/reset on gate 1, R2 gate pointer 9 selected as result
    clear_cfg();
    set_gate(1, 3'd5, 4'hF, 4'h0, 16'h3210);
    cfg_out_ptr = 4'd9;
    begin
      logic s;
      s = 1'b0;
      for (int k = 0; k < 40; k++) begin
        logic [3:0] v;
        v = 4'((k * 7 + 3) % 16);
        if (k % 5 == 0) v = 4'h0;
        inp = {4'h0, v};
        if (v[1]) s = 1'b0;
        else if (v[0]) s = 1'b1;
        else if (v[3]) s = 1'b0;
        else if (v[2]) s = 1'b1;
        @(negedge clk);
        chk("R7 set/reset", {62'd0, gate_live[1], result}, {62'd0, s, s});
      end
    end

    // R12 R2 chain: g0 = i0&i1, g1 = g0|i2, g2 = g1 ^ ~i3, result = ~g2
    clear_cfg();
    set_gate(0, 3'd1, 4'h3, 4'h0, 16'h0010);
    set_gate(1, 3'd2, 4'h3, 4'h0, 16'h0028);
    set_gate(2, 3'd3, 4'h3, 4'h2, 16'h0039);
    cfg_out_ptr = 4'd10; cfg_out_inv = 1'b1;
    for (int iv = 0; iv < 16; iv++) begin
      logic g0, g1, g2;
      inp = {4'h0, 4'(iv)};
      g0 = iv[0] & iv[1]; g1 = g0 | iv[2]; g2 = g1 ^ ~iv[3];
      @(negedge clk);
      chk("R12 chain one pass", {60'd0, gate_live[2:0], result}, {60'd0, g2, g1, g0, ~g2});
    end

    // R10 self and higher pointers, disabled pin pointer ignored
    clear_cfg();
    inp = 8'hFF;
    set_gate(3, 3'd2, 4'h1, 4'h0, 16'h000B);
    set_gate(4, 3'd2, 4'h1, 4'h0, 16'h000E);
    set_gate(5, 3'd2, 4'h1, 4'h0, 16'h00F0);
    @(negedge clk);
    chk("R10 self pointer", {61'd0, err_ptr[3], gate_live[3], pin_live[12]}, {61'd0, 3'b100});
    chk("R10 higher pointer", {62'd0, err_ptr[4], gate_live[4]}, {62'd0, 2'b10});
    chk("R10 disabled pin ptr", {62'd0, err_ptr[5], gate_live[5]}, {62'd0, 2'b01});

    // R8 unused and illegal codes
    clear_cfg();
    set_gate(4, 3'd7, 4'hF, 4'h0, 16'h3210);
    set_gate(6, 3'd0, 4'hF, 4'h0, 16'h3210);
    @(negedge clk);
    chk("R8 code 7", {62'd0, err_func[4], gate_live[4]}, {62'd0, 2'b10});
    chk("R8 unused gate", {60'd0, err_func[6], err_ptr[6], err_mask[6], gate_live[6]}, 64'd0);

    // R11 R2 result from input pointers, both polarities
    clear_cfg();
    inp = 8'hA5;
    for (int p = 0; p < 8; p++)
      for (int v = 0; v < 2; v++) begin
        cfg_out_ptr = 4'(p); cfg_out_inv = 1'(v);
        @(negedge clk);
        chk("R11 output select", {63'd0, result}, {63'd0, inp[p] ^ 1'(v)});
      end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule